// File: doc/BRIEF.md
# Sequential Interleaved Modular Multiplier

This block computes (x · y) mod m for 32-bit unsigned operands. It takes one bit of the multiplier x per clock cycle. A controller on the same clock pulses `start` with the three operands on the inputs. The block latches the operands and scans x from its top bit down to bit 0. At each step it doubles a running partial product, adds y when the current bit of x is set, and then reduces the sum with two compare-and-subtract stages against m. Because of this, the partial product never reaches the modulus and no double-width product is ever built.

The partial product is held in a register two bits wider than the operands. This is enough for the largest intermediate value, 2p + y, which is below 3m. After the final bit, the reduced value is copied to `result` and `done` pulses for one cycle. While a multiplication is running, a new `start` is ignored. The caller must supply x < m and y < m with m nonzero. Results for other inputs are not defined.

Top module: `modmul_seq`

## Requirements
- R1: While `rst_n` is low and after it is released, `done` is 0 and `result` is 0 until a multiplication completes.
- R2: A `start` seen on a rising edge while idle captures `x_in`, `y_in` and `m_in`. `done` is 1 only in the cycle after the 33rd rising edge, counting the capturing edge as the first, and is 0 in the cycle after that.
- R3: When `done` is 1, `result` equals (x·y) mod m for the captured operands, provided x < m, y < m and m ≠ 0.
- R4: The internal partial product stays strictly below the captured m during the whole multiplication, and the result is below m.
- R5: While a multiplication runs, `start` and changes on `x_in`, `y_in` and `m_in` have no effect. The running result is unchanged, and no extra `done` follows.
- R6: `result` holds its value in every cycle in which `done` is 0.
- R7: Boundary values are handled. m = 1 gives 0, x = 0 gives 0, and with m = 2^32−1 and x = y = m−1 the result is 1.
- R8: A `start` given in the same cycle that `done` is 1 is accepted, so multiplications can run back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a multiplication (accepted only when idle) |
| x_in | input | 32 | Multiplier x, scanned from the most significant bit |
| y_in | input | 32 | Multiplicand y |
| m_in | input | 32 | Modulus m |
| result | output | 32 | (x·y) mod m of the last completed multiplication |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
The assertions check the structural invariants on every cycle:
- the partial product stays below the captured modulus;
- `done` lasts exactly one cycle;
- `done` comes exactly 33 edges after the capturing edge;
- `result` is stable outside a `done` cycle;
- the captured operands do not move mid-run.

Only the bench scenarios can show that the value is the correct modular product. This covers:
- the chosen operand patterns and boundary moduli;
- that a `start` during a run leaves the answer and the pulse count untouched;
- that back-to-back starts are accepted.

// File: rtl/modmul_pkg.sv
package modmul_pkg;

  typedef enum logic {
    MM_IDLE = 1'b0,
    MM_RUN  = 1'b1
  } mm_state_e;

  // Headroom bits above the operand width needed to hold 2p + y < 3m.
  localparam int unsigned MM_HEADROOM = 2;

endpackage

// File: rtl/modmul_reduce.sv
module modmul_reduce #(
  parameter int unsigned ACC_W = 34
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [ACC_W-1:0] mod_in,
  output logic [ACC_W-1:0] acc_out
);

  always_comb begin
    if (acc_in >= mod_in) begin
      acc_out = acc_in - mod_in;
    end else begin
      acc_out = acc_in;
    end
  end

endmodule

// File: rtl/modmul_step.sv
module modmul_step #(
  parameter int unsigned OP_W = 32,
  parameter int unsigned NSUB = 2,
  localparam int unsigned ACC_W = OP_W + modmul_pkg::MM_HEADROOM
) (
  input  logic [ACC_W-1:0] p_in,
  input  logic [OP_W-1:0]  y_in,
  input  logic [OP_W-1:0]  m_in,
  input  logic             x_bit,
  output logic [ACC_W-1:0] p_out
);

  logic [ACC_W-1:0] addend;
  logic [ACC_W-1:0] mod_ext;
  logic [ACC_W-1:0] stage [NSUB+1];

  always_comb begin
    mod_ext = {{modmul_pkg::MM_HEADROOM{1'b0}}, m_in};
    if (x_bit) begin
      addend = {{modmul_pkg::MM_HEADROOM{1'b0}}, y_in};
    end else begin
      addend = '0;
    end
    stage[0] = p_in + p_in + addend;
  end

  for (genvar i = 0; i < NSUB; i++) begin : g_sub
    modmul_reduce #(.ACC_W(ACC_W)) u_red (
      .acc_in (stage[i]),
      .mod_in (mod_ext),
      .acc_out(stage[i+1])
    );
  end

  assign p_out = stage[NSUB];

endmodule

// File: rtl/modmul_ctrl.sv
module modmul_ctrl #(
  parameter int unsigned ITER = 32,
  localparam int unsigned CNT_W = (ITER > 1) ? $clog2(ITER) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last,
  output logic done
);

  import modmul_pkg::*;

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ITER - 1);

  mm_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    load    = 1'b0;
    last    = 1'b0;
    unique case (state_q)
      MM_IDLE: begin
        if (start) begin
          load    = 1'b1;
          cnt_en  = 1'b1;
          cnt_d   = '0;
          state_d = MM_RUN;
        end
      end
      MM_RUN: begin
        cnt_en = 1'b1;
        if (cnt_q == CNT_LAST) begin
          last    = 1'b1;
          cnt_d   = '0;
          state_d = MM_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: state_d = MM_IDLE;
    endcase
    done_d = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MM_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign busy = (state_q == MM_RUN);
  assign done = done_q;

endmodule

// File: rtl/modmul_seq.sv
module modmul_seq #(
  parameter int unsigned OP_W = 32,
  parameter int unsigned NSUB = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [OP_W-1:0] x_in,
  input  logic [OP_W-1:0] y_in,
  input  logic [OP_W-1:0] m_in,
  output logic [OP_W-1:0] result,
  output logic            done
);

  localparam int unsigned ACC_W = OP_W + modmul_pkg::MM_HEADROOM;

  logic             busy;
  logic             load;
  logic             last;
  logic [OP_W-1:0]  x_sh_q, x_sh_d;
  logic [OP_W-1:0]  y_q;
  logic [OP_W-1:0]  m_q;
  logic [ACC_W-1:0] p_q, p_d;
  logic [ACC_W-1:0] p_next;
  logic [OP_W-1:0]  result_q;
  logic             op_en;
  logic             acc_en;

  modmul_ctrl #(.ITER(OP_W)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .start(start),
    .busy (busy),
    .load (load),
    .last (last),
    .done (done)
  );

  modmul_step #(.OP_W(OP_W), .NSUB(NSUB)) u_step (
    .p_in (p_q),
    .y_in (y_q),
    .m_in (m_q),
    .x_bit(x_sh_q[OP_W-1]),
    .p_out(p_next)
  );

  always_comb begin
    op_en  = load;
    acc_en = load | busy;
    if (load) begin
      x_sh_d = x_in;
      p_d    = '0;
    end else begin
      x_sh_d = {x_sh_q[OP_W-2:0], 1'b0};
      p_d    = p_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_q <= '0;
      m_q <= '0;
    end else if (op_en) begin
      y_q <= y_in;
      m_q <= m_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_sh_q <= '0;
      p_q    <= '0;
    end else if (acc_en) begin
      x_sh_q <= x_sh_d;
      p_q    <= p_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q <= '0;
    end else if (last) begin
      result_q <= p_next[OP_W-1:0];
    end
  end

  assign result = result_q;

endmodule

// File: rtl/modmul_seq_chk.sv
module modmul_seq_chk #(
  parameter int unsigned OP_W  = 32,
  parameter int unsigned ACC_W = 34
) (
  input logic             clk,
  input logic             rst_n,
  input logic             done,
  input logic             busy,
  input logic             load,
  input logic             last,
  input logic [OP_W-1:0]  result,
  input logic [OP_W-1:0]  m_q,
  input logic [OP_W-1:0]  y_q,
  input logic [ACC_W-1:0] p_q
);

  localparam int unsigned LAT   = OP_W + 1;
  localparam int unsigned LAT_W = $clog2(LAT + 1);
  localparam logic [LAT_W-1:0] LAT_V = LAT_W'(LAT);

  logic [LAT_W-1:0] lat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else if (load) begin
      lat_q <= LAT_W'(1);
    end else if (lat_q != '0 && lat_q != LAT_V) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_q == LAT_V));

  // R4
  partial_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (p_q < {2'b00, m_q}));

  // R4
  result_below_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result < m_q));

  // R5
  operands_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> (busy && $stable(m_q) && $stable(y_q)));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

bind modmul_seq modmul_seq_chk #(.OP_W(OP_W), .ACC_W(ACC_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .done  (done),
  .busy  (busy),
  .load  (load),
  .last  (last),
  .result(result),
  .m_q   (m_q),
  .y_q   (y_q),
  .p_q   (p_q)
);

// File: tb/tb_modmul_seq.sv
module tb_modmul_seq;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [31:0] x_in, y_in, m_in;
  logic [31:0] result;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  modmul_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .x_in(x_in), .y_in(y_in), .m_in(m_in),
    .result(result), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ref_mod(input logic [31:0] a, b, m);
    logic [63:0] prod;
    prod = {32'd0, a} * {32'd0, b};
    return 32'(prod % {32'd0, m});
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive start at a negedge; returns at the negedge after the capturing edge.
  task automatic issue(input logic [31:0] a, b, m);
    x_in = a; y_in = b; m_in = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Called one negedge after issue; ends at the negedge where done should be 1.
  task automatic await_done(input logic [31:0] exp, input string req);
    repeat (31) @(negedge clk);
    check(done == 1'b0, "R2 early done", 32'(done), 32'd0);
    @(negedge clk);
    check(done == 1'b1, "R2 done timing", 32'(done), 32'd1);
    check(result == exp, req, result, exp);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; x_in = '0; y_in = '0; m_in = '0;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done in reset", 32'(done), 0);
    check(result == 32'd0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && result == 32'd0, "R1 after release", result, 0);
  endtask

  task automatic test_basic(input logic [31:0] a, b, m);
    issue(a, b, m);
    await_done(ref_mod(a, b, m), "R3 product");
    @(negedge clk);
    check(done == 1'b0, "R2 pulse width", 32'(done), 0);
  endtask

  task automatic test_boundaries();
    issue(32'd0, 32'd0, 32'd1);
    await_done(32'd0, "R7 m=1");
    @(negedge clk);
    issue(32'd0, 32'hDEAD_BEEF, 32'hFFFF_FFFB);
    await_done(32'd0, "R7 x=0");
    @(negedge clk);
    issue(32'hFFFF_FFFE, 32'hFFFF_FFFE, 32'hFFFF_FFFF);
    await_done(32'd1, "R7 max modulus");
    @(negedge clk);
  endtask

  task automatic test_back_to_back();
    issue(32'd12345, 32'd67890, 32'd99991);
    await_done(ref_mod(32'd12345, 32'd67890, 32'd99991), "R8 first");
    issue(32'h7FFF_0001, 32'h1234_5678, 32'h8000_0001);
    await_done(ref_mod(32'h7FFF_0001, 32'h1234_5678, 32'h8000_0001), "R8 second accepted");
    @(negedge clk);
  endtask

  task automatic test_ignore_and_hold();
    logic [31:0] exp_a;
    int extra;
    exp_a = ref_mod(32'd1000003, 32'd999983, 32'd2147483629);
    issue(32'd1000003, 32'd999983, 32'd2147483629);
    repeat (4) @(negedge clk);
    x_in = 32'd5; y_in = 32'd7; m_in = 32'd11; start = 1'b1;
    @(negedge clk);
    start = 1'b0; x_in = 32'hAAAA_AAAA; m_in = 32'd3;
    repeat (26) @(negedge clk);
    check(done == 1'b0, "R5 early done", 32'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R5 done timing", 32'(done), 1);
    check(result == exp_a, "R5 start ignored", result, exp_a);
    extra = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R5 no extra done", 32'(extra), 0);
    check(result == exp_a, "R6 result held", result, exp_a);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    test_reset();
    test_basic(32'd3, 32'd5, 32'd7);
    test_basic(32'hFFFF_FFF0, 32'hFFFF_FFF0, 32'hFFFF_FFF1);
    test_basic(32'h8000_0000, 32'h4000_0001, 32'hC000_0005);
    test_basic(32'd1, 32'h1234_5677, 32'h1234_5678);
    test_basic(32'h5555_5555, 32'h3333_3333, 32'h6000_0007);
    test_boundaries();
    test_back_to_back();
    test_ignore_and_hold();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule